// File: doc/BRIEF.md
# Expansion Bus Request Holdoff Timer

This block drives the request line of a shared expansion bus. An internal "want bus" signal starts a request. The request stays up until the external arbiter grants the bus and the local side then reports that it is done. When the bus is released, the block enforces a quiet gap before it may request again. The gap lasts a programmable number of bus clock periods, so that the arbiter has time to drop its grant lines after the request falls.

The gap length comes from a 3-bit field of a 32-bit configuration word and is always four cycles more than the field value. The same word also holds an enable bit for the expansion bus clock pin. When that bit is set, the pin carries the inverted system clock. When it is clear, the pin's output enable is low so that the pad floats. Arbitration policy and data movement belong to other blocks.

Top module: `xbus_holdoff`

## Requirements
- R1: After reset, busReq is 0, busClkOe is 0 and busClkOut is 0.
- R2: From idle, wantBus high at a rising edge makes busReq 1 after that edge.
- R3: Once raised, busReq stays 1 until doneBus is sampled high after busGrant has been sampled high. A doneBus pulse that arrives before the grant is ignored.
- R4: After the release, busReq stays 0 for exactly H+4 cycles when wantBus is held high. H is the unsigned field at cfgWord bits 14:12, so the gap runs from 4 to 11 cycles.
- R5: While the gap is running, wantBus has no effect, and busReq stays 0 even if wantBus toggles.
- R6: The gap uses H as sampled at the release edge. Changing H during a gap affects only the next release.
- R7: One cycle after cfgWord bit 11 is sampled as 1, busClkOe is 1 and busClkOut is the inverse of clk.
- R8: One cycle after cfgWord bit 11 is sampled as 0, busClkOe is 0 and busClkOut is 0.
- R9: If wantBus is low when the gap ends, busReq stays 0. It rises one edge after wantBus is next sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWord | input | 32 | Configuration word: bits 14:12 holdoff field, bit 11 bus clock enable |
| wantBus | input | 1 | Local side wants the bus |
| doneBus | input | 1 | Local side has finished with the bus |
| busGrant | input | 1 | Grant from the external arbiter |
| busReq | output | 1 | Bus request to the arbiter |
| busClkOut | output | 1 | Expansion bus clock pin data |
| busClkOe | output | 1 | Expansion bus clock pin output enable |

## Verification
A wrong holdoff count shows up within one release: busReq comes back one or more cycles too early or too late, and sweeping all eight field values exposes an off-by-one at either end of the range. If the controller were stuck in the wrong state, busReq would be wrong on the very next cycle: it would stay high after a release, rise during the gap, or fall before doneBus. A wrong clock-enable register shows up one cycle after the configuration changes, in busClkOe and in the phase of busClkOut.

// File: rtl/xbus_holdoff_pkg.sv
package xbus_holdoff_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_OWN  = 2'd2,
    ST_HOLD = 2'd3
  } busState_t;

  typedef struct packed {
    logic loadCnt;  // start the holdoff window
    logic decCnt;   // count one bus clock of holdoff
  } holdStrobe_t;
endpackage

// File: rtl/xbus_holdoff_ctrl.sv
module xbus_holdoff_ctrl
  import xbus_holdoff_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wantBus,
  input  logic        doneBus,
  input  logic        busGrant,
  input  logic        cntLast,
  output holdStrobe_t strobe,
  output logic        busReq
);
  busState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (wantBus) stateNxt = ST_REQ;
      ST_REQ:  if (busGrant) stateNxt = ST_OWN;
      ST_OWN:  if (doneBus) stateNxt = ST_HOLD;
      ST_HOLD: if (cntLast) stateNxt = wantBus ? ST_REQ : ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    strobe.loadCnt = (state == ST_OWN) && doneBus;
    strobe.decCnt  = (state == ST_HOLD);
  end

  assign busReq = (state == ST_REQ) || (state == ST_OWN);
endmodule

// File: rtl/xbus_holdoff_dp.sv
module xbus_holdoff_dp
  import xbus_holdoff_pkg::*;
#(
  parameter int CFG_W     = 32,
  parameter int FIELD_LSB = 12,
  parameter int FIELD_W   = 3,
  parameter int CLKEN_BIT = 11,
  parameter int HOLD_BASE = 4,
  localparam int HOLD_MAX = (1 << FIELD_W) - 1 + HOLD_BASE,
  localparam int CNT_W    = $clog2(HOLD_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgWord,
  input  holdStrobe_t      strobe,
  output logic             cntLast,
  output logic             busClkOut,
  output logic             busClkOe
);
  logic [CNT_W-1:0]   holdCnt;
  logic [FIELD_W-1:0] holdField;
  logic               clkEnQ;

  assign holdField = cfgWord[FIELD_LSB +: FIELD_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (strobe.loadCnt) begin
      holdCnt <= CNT_W'(holdField) + CNT_W'(HOLD_BASE);
    end else if (strobe.decCnt && holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  assign cntLast = (holdCnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkEnQ <= 1'b0;
    else       clkEnQ <= cfgWord[CLKEN_BIT];
  end

  assign busClkOe  = clkEnQ;
  assign busClkOut = clkEnQ & ~clk;
endmodule

// File: rtl/xbus_holdoff.sv
module xbus_holdoff
  import xbus_holdoff_pkg::*;
#(
  parameter int CFG_W     = 32,
  parameter int FIELD_LSB = 12,
  parameter int FIELD_W   = 3,
  parameter int CLKEN_BIT = 11,
  parameter int HOLD_BASE = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             wantBus,
  input  logic             doneBus,
  input  logic             busGrant,
  output logic             busReq,
  output logic             busClkOut,
  output logic             busClkOe
);
  holdStrobe_t strobe;
  logic        cntLast;

  xbus_holdoff_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wantBus(wantBus), .doneBus(doneBus),
    .busGrant(busGrant), .cntLast(cntLast), .strobe(strobe), .busReq(busReq)
  );

  xbus_holdoff_dp #(
    .CFG_W(CFG_W), .FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W),
    .CLKEN_BIT(CLKEN_BIT), .HOLD_BASE(HOLD_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .strobe(strobe),
    .cntLast(cntLast), .busClkOut(busClkOut), .busClkOe(busClkOe)
  );
endmodule

// File: rtl/xbus_holdoff_chk.sv
module xbus_holdoff_chk #(
  parameter int CFG_W     = 32,
  parameter int FIELD_LSB = 12,
  parameter int FIELD_W   = 3,
  parameter int CLKEN_BIT = 11,
  parameter int HOLD_BASE = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [CFG_W-1:0] cfgWord,
  input logic             wantBus,
  input logic             doneBus,
  input logic             busGrant,
  input logic             busReq,
  input logic             busClkOut,
  input logic             busClkOe
);
  logic [4:0] lowCnt;
  logic [4:0] needGap;
  logic       released;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt   <= '0;
      needGap  <= '0;
      released <= 1'b0;
    end else begin
      if (busReq) begin
        lowCnt   <= '0;
        needGap  <= 5'(cfgWord[FIELD_LSB +: FIELD_W]) + 5'(HOLD_BASE);
        released <= 1'b1;
      end else if (lowCnt != 5'd31) begin
        lowCnt <= lowCnt + 1'b1;
      end
    end
  end

  // R4
  min_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (released && $rose(busReq)) |-> (lowCnt >= needGap));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busReq) && !$past(doneBus)) |-> busReq);

  // R3
  release_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busReq) |-> $past(doneBus));

  // R7
  clk_oe_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (busClkOe == $past(cfgWord[CLKEN_BIT])));

  // R8
  clk_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busClkOe |-> !busClkOut);
endmodule

bind xbus_holdoff xbus_holdoff_chk #(
  .CFG_W(CFG_W), .FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W),
  .CLKEN_BIT(CLKEN_BIT), .HOLD_BASE(HOLD_BASE)
) chk (
  .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .wantBus(wantBus),
  .doneBus(doneBus), .busGrant(busGrant), .busReq(busReq),
  .busClkOut(busClkOut), .busClkOe(busClkOe)
);

// File: tb/xbus_holdoff_test.sv
`timescale 1ns/1ps
module xbus_holdoff_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgWord = '0;
  logic        wantBus = 1'b0;
  logic        doneBus = 1'b0;
  logic        busGrant = 1'b0;
  logic        busReq, busClkOut, busClkOe;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  xbus_holdoff uut (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .wantBus(wantBus),
    .doneBus(doneBus), .busGrant(busGrant), .busReq(busReq),
    .busClkOut(busClkOut), .busClkOe(busClkOe)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setField(input int h);
    cfgWord[14:12] = 3'(h);
  endtask

  // wait (at falling edges) until busReq is high, at most 20 cycles
  task automatic waitReq();
    for (int i = 0; i < 20 && !busReq; i++) @(negedge clk);
  endtask

  // grant, release, then count low cycles until busReq returns
  task automatic releaseAndMeasure(output int gap);
    waitReq();
    busGrant = 1'b1;
    @(negedge clk);
    doneBus = 1'b1;
    @(negedge clk);
    doneBus = 1'b0;
    busGrant = 1'b0;
    gap = 0;
    for (int i = 0; i < 40 && !busReq; i++) begin
      gap++;
      @(negedge clk);
    end
  endtask

  initial begin
    int gap;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busReq", int'(busReq), 0);
    check("R1 busClkOe", int'(busClkOe), 0);
    check("R1 busClkOut", int'(busClkOut), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle without want", int'(busReq), 0);

    // R2 request follows want by one edge
    wantBus = 1'b1;
    @(negedge clk);
    check("R2 request raised", int'(busReq), 1);

    // R3 done before grant is ignored
    doneBus = 1'b1;
    @(negedge clk);
    doneBus = 1'b0;
    @(negedge clk);
    check("R3 done before grant ignored", int'(busReq), 1);
    busGrant = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 held while owned", int'(busReq), 1);
    busGrant = 1'b0;

    // R4 sweep of every field value with wantBus held high
    for (int h = 0; h < 8; h++) begin
      setField(h);
      releaseAndMeasure(gap);
      check($sformatf("R4 gap field=%0d", h), gap, h + 4);
    end

    // R6 field change during the gap takes effect at the next release
    setField(0);
    waitReq();
    busGrant = 1'b1;
    @(negedge clk);
    doneBus = 1'b1;
    @(negedge clk);
    doneBus = 1'b0;
    busGrant = 1'b0;
    setField(7);
    gap = 0;
    for (int i = 0; i < 40 && !busReq; i++) begin
      gap++;
      @(negedge clk);
    end
    check("R6 gap uses field at release", gap, 4);
    releaseAndMeasure(gap);
    check("R6 new field at next release", gap, 11);

    // R5 want toggling during the gap has no effect
    setField(5);
    waitReq();
    busGrant = 1'b1;
    @(negedge clk);
    doneBus = 1'b1;
    @(negedge clk);
    doneBus = 1'b0;
    busGrant = 1'b0;
    gap = 0;
    for (int i = 0; i < 40 && !busReq; i++) begin
      wantBus = (i % 2 == 0);
      gap++;
      @(negedge clk);
    end
    check("R5 gap with toggling want", gap, 9);

    // R9 want low at gap end: stay idle, then request one edge after want
    setField(2);
    waitReq();
    busGrant = 1'b1;
    @(negedge clk);
    doneBus = 1'b1;
    wantBus = 1'b0;
    @(negedge clk);
    doneBus = 1'b0;
    busGrant = 1'b0;
    repeat (12) @(negedge clk);
    check("R9 idle after gap without want", int'(busReq), 0);
    wantBus = 1'b1;
    @(negedge clk);
    check("R9 request after want returns", int'(busReq), 1);

    // R7 clock enabled: inverted system clock
    cfgWord[11] = 1'b1;
    @(negedge clk);
    check("R7 busClkOe", int'(busClkOe), 1);
    check("R7 busClkOut while clk low", int'(busClkOut), 1);
    @(posedge clk);
    #5;
    check("R7 busClkOut while clk high", int'(busClkOut), 0);

    // R8 clock disabled: pad floats, data low
    @(negedge clk);
    cfgWord[11] = 1'b0;
    @(negedge clk);
    check("R8 busClkOe", int'(busClkOe), 0);
    check("R8 busClkOut", int'(busClkOut), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule